// File: doc/BRIEF.md
# Engine Enable and Clamp Control Registers

This block is a small memory-mapped register slave that owns three control words for one graphics engine and its power switch. The first word holds an engine enable and an enable for the engine's block-level gating controllers. The second word holds a clamp mask and a clamp value. The third word holds an override enable and an override value for the power-gate-on-boot state. The block turns these words into four registered control outputs. An engine reset is held active while the engine is disabled. A clamp enable follows the power controller's request unless the mask forces a software value. A power-gate-on-boot state follows the boot strap unless the override selects a software value. A gating-active signal is raised only when the gating controllers are enabled and the engine is out of reset.

Software uses read-modify-write on every word. Bits that have no function read as zero and ignore writes, so a read-modify-write never disturbs them. Reads are combinational on the request cycle. Writes land on the clock edge that accepts them. The outputs are registered from the stored fields and the two live inputs, so each change reaches the outputs one cycle later.

Top module: `engclamp_regs`

## Requirements
- R1: After reset all three words read 0, engineReset is 1, and gatingActive, clampEn and pgobState are 0.
- R2: The engine word sits at offset 0x200, with the engine enable in bit 12. engineReset is the inverse of that bit.
- R3: Bit 27 of the engine word is the gating-controller enable. gatingActive is 1 only when bit 27 and bit 12 are both 1.
- R4: The clamp word sits at offset 0x204, with the mask in bit 0 and the value in bit 1. When the mask is 1, clampEn equals the value bit. When the mask is 0, clampEn follows clampReq.
- R5: The override word sits at offset 0x208, with the override enable in bit 30 and the override value in bit 31 (0 = gating off). When the override enable is 1, pgobState equals the value bit. Otherwise pgobState follows bootStrap.
- R6: Every bit of a mapped word other than its defined fields reads 0, and writes to such bits are ignored.
- R7: A read from any other offset returns 0. A write to any other offset changes no stored field.
- R8: Every output reflects the stored fields and inputs of the previous clock edge. A write accepted at edge N changes the outputs at edge N+1.
- R9: busRdata is 0 in every cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the request cycle |
| clampReq | input | 1 | Clamp request from the power controller |
| bootStrap | input | 1 | Boot-time power-gate strap |
| engineReset | output | 1 | Engine reset, active high |
| gatingActive | output | 1 | Gating controllers running |
| clampEn | output | 1 | Power-switch clamp enable |
| pgobState | output | 1 | Power-gate-on-boot state |

## Verification
The bench writes all ones to each word to find reserved bits that get stored or read back. A design with a wide write mask would return those bits and fail the read-modify-write rule. Writes to unmapped offsets are followed by a read-back of all three words, which exposes address aliasing that corrupts a real word. The bench checks the outputs one edge after a write and again the edge after that, so a design with the mux latency off by one cycle fails. Random patterns toggle the mask and override bits against changing clampReq and bootStrap, which catches inverted mux selects. The bench also sets the gating enable while the engine is disabled, which catches a gatingActive that ignores the engine reset.

// File: rtl/engclamp_pkg.sv
package engclamp_pkg;
  localparam int DATA_W     = 32;
  localparam int ENG_BIT    = 12;
  localparam int GATE_BIT   = 27;
  localparam int MASK_BIT   = 0;
  localparam int VAL_BIT    = 1;
  localparam int OVR_EN_BIT = 30;
  localparam int OVR_VAL_BIT = 31;

  typedef enum logic [1:0] {SEL_NONE, SEL_ENG, SEL_CLAMP, SEL_OVR} regSel_e;

  typedef struct packed {
    logic    wrEng;
    logic    wrClamp;
    logic    wrOvr;
    regSel_e rdSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic engEn;
    logic gateEn;
    logic clampMask;
    logic clampVal;
    logic ovrEn;
    logic ovrVal;
  } regState_t;
endpackage

// File: rtl/engclamp_decode.sv
module engclamp_decode
  import engclamp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ENG_OFF   = 12'h200,
  parameter logic [ADDR_W-1:0] CLAMP_OFF = 12'h204,
  parameter logic [ADDR_W-1:0] OVR_OFF   = 12'h208
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  logic hitEng, hitClamp, hitOvr, isWr, isRd;

  always_comb begin
    hitEng   = (busAddr == ENG_OFF);
    hitClamp = (busAddr == CLAMP_OFF);
    hitOvr   = (busAddr == OVR_OFF);
    isWr     = busValid && busWrite;
    isRd     = busValid && !busWrite;

    strobe.wrEng   = isWr && hitEng;
    strobe.wrClamp = isWr && hitClamp;
    strobe.wrOvr   = isWr && hitOvr;

    strobe.rdSel = SEL_NONE;
    if (isRd) begin
      if (hitEng)        strobe.rdSel = SEL_ENG;
      else if (hitClamp) strobe.rdSel = SEL_CLAMP;
      else if (hitOvr)   strobe.rdSel = SEL_OVR;
    end
  end
endmodule

// File: rtl/engclamp_store.sv
module engclamp_store
  import engclamp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              clampReq,
  input  logic              bootStrap,
  output regState_t         state,
  output logic [DATA_W-1:0] busRdata,
  output logic              engineReset,
  output logic              gatingActive,
  output logic              clampEn,
  output logic              pgobState
);
  // Only the defined field bits are consumed; the rest are reserved.
  logic unusedWdataBits;
  assign unusedWdataBits = ^busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= '0;
    end else begin
      if (strobe.wrEng) begin
        state.engEn  <= busWdata[ENG_BIT];
        state.gateEn <= busWdata[GATE_BIT];
      end
      if (strobe.wrClamp) begin
        state.clampMask <= busWdata[MASK_BIT];
        state.clampVal  <= busWdata[VAL_BIT];
      end
      if (strobe.wrOvr) begin
        state.ovrEn  <= busWdata[OVR_EN_BIT];
        state.ovrVal <= busWdata[OVR_VAL_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engineReset  <= 1'b1;
      gatingActive <= 1'b0;
      clampEn      <= 1'b0;
      pgobState    <= 1'b0;
    end else begin
      engineReset  <= !state.engEn;
      gatingActive <= state.gateEn && state.engEn;
      clampEn      <= state.clampMask ? state.clampVal : clampReq;
      pgobState    <= state.ovrEn ? state.ovrVal : bootStrap;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strobe.rdSel)
      SEL_ENG: begin
        busRdata[ENG_BIT]  = state.engEn;
        busRdata[GATE_BIT] = state.gateEn;
      end
      SEL_CLAMP: begin
        busRdata[MASK_BIT] = state.clampMask;
        busRdata[VAL_BIT]  = state.clampVal;
      end
      SEL_OVR: begin
        busRdata[OVR_EN_BIT]  = state.ovrEn;
        busRdata[OVR_VAL_BIT] = state.ovrVal;
      end
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/engclamp_regs.sv
module engclamp_regs
  import engclamp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ENG_OFF   = 12'h200,
  parameter logic [ADDR_W-1:0] CLAMP_OFF = 12'h204,
  parameter logic [ADDR_W-1:0] OVR_OFF   = 12'h208
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              clampReq,
  input  logic              bootStrap,
  output logic              engineReset,
  output logic              gatingActive,
  output logic              clampEn,
  output logic              pgobState
);
  ctrlStrobe_t strobe;
  regState_t   state;

  engclamp_decode #(
    .ADDR_W(ADDR_W), .ENG_OFF(ENG_OFF), .CLAMP_OFF(CLAMP_OFF), .OVR_OFF(OVR_OFF)
  ) uDecode (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  engclamp_store uStore (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busWdata    (busWdata),
    .clampReq    (clampReq),
    .bootStrap   (bootStrap),
    .state       (state),
    .busRdata    (busRdata),
    .engineReset (engineReset),
    .gatingActive(gatingActive),
    .clampEn     (clampEn),
    .pgobState   (pgobState)
  );
endmodule

// File: rtl/engclamp_chk.sv
module engclamp_chk
  import engclamp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ENG_OFF   = 12'h200,
  parameter logic [ADDR_W-1:0] CLAMP_OFF = 12'h204,
  parameter logic [ADDR_W-1:0] OVR_OFF   = 12'h208
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              clampReq,
  input logic              bootStrap,
  input logic              engineReset,
  input logic              gatingActive,
  input logic              clampEn,
  input logic              pgobState,
  input regState_t         state
);
  function automatic logic [31:0] legalBits(input logic [ADDR_W-1:0] a);
    logic [31:0] m;
    m = '0;
    if (a == ENG_OFF) begin
      m[ENG_BIT] = 1'b1; m[GATE_BIT] = 1'b1;
    end else if (a == CLAMP_OFF) begin
      m[MASK_BIT] = 1'b1; m[VAL_BIT] = 1'b1;
    end else if (a == OVR_OFF) begin
      m[OVR_EN_BIT] = 1'b1; m[OVR_VAL_BIT] = 1'b1;
    end
    return m;
  endfunction

  logic unmappedAddr;
  assign unmappedAddr = (busAddr != ENG_OFF) && (busAddr != CLAMP_OFF) && (busAddr != OVR_OFF);

  // R2 / R8
  a_r2_reset_follows_enable: assert property (@(posedge clk) disable iff (!rstN)
    engineReset == !$past(state.engEn));
  // R3
  a_r3_gating_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    gatingActive |-> $past(state.engEn && state.gateEn));
  a_r3_gating_when_both: assert property (@(posedge clk) disable iff (!rstN)
    $past(state.engEn && state.gateEn) |-> gatingActive);
  // R4
  a_r4_clamp_forced: assert property (@(posedge clk) disable iff (!rstN)
    $past(state.clampMask) |-> clampEn == $past(state.clampVal));
  a_r4_clamp_follows: assert property (@(posedge clk) disable iff (!rstN)
    !$past(state.clampMask) |-> clampEn == $past(clampReq));
  // R5
  a_r5_pgob_forced: assert property (@(posedge clk) disable iff (!rstN)
    $past(state.ovrEn) |-> pgobState == $past(state.ovrVal));
  a_r5_pgob_follows: assert property (@(posedge clk) disable iff (!rstN)
    !$past(state.ovrEn) |-> pgobState == $past(bootStrap));
  // R6 and R7: read data never carries bits outside the defined fields
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |-> ((busRdata & ~legalBits(busAddr)) == '0));
  // R7
  a_r7_unmapped_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && unmappedAddr) |=> $stable(state));
  // R9
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |-> busRdata == '0);
endmodule

bind engclamp_regs engclamp_chk #(
  .ADDR_W(ADDR_W), .ENG_OFF(ENG_OFF), .CLAMP_OFF(CLAMP_OFF), .OVR_OFF(OVR_OFF)
) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .clampReq(clampReq),
  .bootStrap(bootStrap), .engineReset(engineReset), .gatingActive(gatingActive),
  .clampEn(clampEn), .pgobState(pgobState), .state(state)
);

// File: tb/tb_engclamp_regs.sv
`timescale 1ns/1ps
module tb_engclamp_regs;
  localparam int ADDR_W = 12;
  localparam logic [11:0] A_ENG = 12'h200, A_CLAMP = 12'h204, A_OVR = 12'h208;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic clampReq = 1'b0, bootStrap = 1'b0;
  logic engineReset, gatingActive, clampEn, pgobState;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the stored fields
  logic mEng = 0, mGate = 0, mMask = 0, mVal = 0, mOvrEn = 0, mOvrVal = 0;

  always #10 clk = ~clk;

  engclamp_regs dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .clampReq(clampReq), .bootStrap(bootStrap), .engineReset(engineReset),
    .gatingActive(gatingActive), .clampEn(clampEn), .pgobState(pgobState)
  );

  function automatic logic [31:0] expWord(input logic [11:0] a);
    logic [31:0] w;
    w = '0;
    if (a == A_ENG) begin w[12] = mEng; w[27] = mGate; end
    else if (a == A_CLAMP) begin w[0] = mMask; w[1] = mVal; end
    else if (a == A_OVR) begin w[30] = mOvrEn; w[31] = mOvrVal; end
    return w;
  endfunction

  function automatic logic [3:0] expOuts();
    return {!mEng, mGate && mEng, mMask ? mVal : clampReq, mOvrEn ? mOvrVal : bootStrap};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
    if (a == A_ENG) begin mEng = d[12]; mGate = d[27]; end
    else if (a == A_CLAMP) begin mMask = d[0]; mVal = d[1]; end
    else if (a == A_OVR) begin mOvrEn = d[30]; mOvrVal = d[31]; end
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    busValid = 1; busWrite = 0; busAddr = a;
    #2 d = busRdata;
    busValid = 0;
    #1;
  endtask

  task automatic checkOuts(input string tag);
    chk(tag, {28'd0, engineReset, gatingActive, clampEn, pgobState}, {28'd0, expOuts()});
  endtask

  task automatic checkWords(input string tag);
    logic [31:0] d;
    busRd(A_ENG, d);   chk({tag, " R2 R3 engine word"}, d, expWord(A_ENG));
    busRd(A_CLAMP, d); chk({tag, " R4 clamp word"}, d, expWord(A_CLAMP));
    busRd(A_OVR, d);   chk({tag, " R5 override word"}, d, expWord(A_OVR));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 engineReset", {31'd0, engineReset}, 32'd1);
    chk("R1 gatingActive", {31'd0, gatingActive}, 32'd0);
    checkWords("R1");
    // R9: idle read data
    chk("R9 idle rdata", busRdata, 32'd0);

    // R6: all-ones write, only defined bits stick
    busWr(A_ENG, 32'hFFFF_FFFF);
    busWr(A_CLAMP, 32'hFFFF_FFFF);
    busWr(A_OVR, 32'hFFFF_FFFF);
    checkWords("R6 reserved");
    @(negedge clk);
    checkOuts("R6 R4 R5 forced outputs");

    // R3: gating enabled while engine disabled
    busWr(A_ENG, 32'h0800_0000);
    @(negedge clk);
    checkOuts("R3 gate without engine");
    chk("R3 gatingActive low", {31'd0, gatingActive}, 32'd0);

    // R8: latency, write accepted at edge N, outputs change at edge N+1
    busWr(A_ENG, 32'h0800_1000);
    chk("R8 one edge after write", {31'd0, engineReset}, 32'd1);
    @(negedge clk);
    chk("R8 R2 two edges after write", {31'd0, engineReset}, 32'd0);
    chk("R8 R3 gatingActive", {31'd0, gatingActive}, 32'd1);

    // R7: unmapped writes and reads
    busWr(12'h20C, 32'hFFFF_FFFF);
    busWr(12'h000, 32'h0000_0000);
    busWr(12'hA00, 32'h0000_0000);
    checkWords("R7 after unmapped writes");
    busRd(12'h20C, d); chk("R7 unmapped read", d, 32'd0);
    busRd(12'h1FC, d); chk("R7 unmapped read low", d, 32'd0);

    // R4 / R5: mask off, outputs follow live inputs
    busWr(A_CLAMP, 32'h0000_0002);
    busWr(A_OVR, 32'h8000_0000);
    clampReq = 1; bootStrap = 1;
    @(negedge clk);
    checkOuts("R4 R5 follow inputs high");
    clampReq = 0; bootStrap = 0;
    @(negedge clk);
    checkOuts("R4 R5 follow inputs low");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      int pick;
      pick = $urandom % 4;
      case (pick)
        0: a = A_ENG;
        1: a = A_CLAMP;
        2: a = A_OVR;
        default: begin
          a = 12'($urandom);
          if (a == A_ENG || a == A_CLAMP || a == A_OVR) a = a ^ 12'h010;
        end
      endcase
      clampReq = 1'($urandom);
      bootStrap = 1'($urandom);
      busWr(a, $urandom);
      @(negedge clk);
      checkOuts("R2 R3 R4 R5 random outputs");
      checkWords("R6 R7 random");
      chk("R9 random idle", busRdata, 32'd0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule